// File: doc/BRIEF.md
# Interrupt Pending Tracker

This block keeps, for every interrupt source of a single processor, the recorded line level, an enable flag, a trigger configuration and a stored pending flag. Pending state is raised by line transitions, by software set-pending writes and by enable writes. It is lowered by acknowledge events and clear-pending writes. The reported pending vector feeds a priority selector placed downstream.

Two behaviours are offered through the `REV` parameter. In the legacy flavour, a level-triggered source only latches pending on a rising line while enabled, and it is latched again at end of interrupt if it is enabled and its line is still high. In the generic flavour, a level-triggered source reports pending whenever its line is high, in addition to any stored flag. Line inputs are asynchronous and pass through two flops before the edge decision.

Top module: `itp_pending_tracker`

## Requirements
- R1: Line inputs pass two synchronising flops and one level-record flop, so a line change shows on `pend_o` on the third rising clock edge. Only a transition of the recorded level acts: a line that stays high does not pend a source again after it is acknowledged.
- R2: A rising line on an edge-triggered source sets its stored pending flag in both flavours, whether or not the source is enabled.
- R3: In the legacy flavour, a rising line on a level-triggered source sets pending only if the source is enabled. A falling line does not clear the stored flag.
- R4: In the generic flavour, a level-triggered source reports pending while its recorded line is high, and reports the stored flag alone once the line is low.
- R5: An acknowledge (`ack_valid_i` with `ack_id_i`) clears the stored pending flag of that source for both trigger types. A generic level source whose line is still high keeps reporting pending.
- R6: In the legacy flavour, an end of interrupt (`eoi_valid_i` with `eoi_id_i`) sets pending again for a level-triggered source that is enabled and whose line is high. In every other case, including the generic flavour, it has no effect.
- R7: A write with `wr_sel_i`=0 (set-enable) maps `wr_data_i` bit k of byte index b to source 8b+k. A 1 enables that source, and a level-triggered source with its line high also becomes stored pending. A 0 bit has no effect.
- R8: A write with `wr_sel_i`=1 (clear-enable) uses the same mapping. A 1 disables the source and a 0 has no effect.
- R9: Writes with `wr_sel_i`=2 (set-pending) and 3 (clear-pending) use the same mapping, with 1 acting and 0 ignored. When a clear (clear-pending or acknowledge) and any set hit one source in the same cycle, the clear wins.
- R10: A write with `wr_sel_i`=4 (configuration) covers sources 4b..4b+3 of byte index b. For source 4b+k, bit 2k+1 selects edge triggering and bit 2k is a stored model bit. Selector codes 5 to 7 and bitmap byte indices beyond the source count are ignored.
- R11: After reset, all pending, enable, edge and model flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | NUM_SRC | Asynchronous interrupt lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write target: 0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending, 4 configuration |
| wr_idx_i | input | IDX_W | Byte index within the selected target |
| wr_data_i | input | 8 | Write byte |
| ack_valid_i | input | 1 | Acknowledge event |
| ack_id_i | input | ID_W | Acknowledged source |
| eoi_valid_i | input | 1 | End-of-interrupt event |
| eoi_id_i | input | ID_W | Completed source |
| pend_o | output | NUM_SRC | Reported pending vector |
| enable_o | output | NUM_SRC | Enable flags |
| edge_cfg_o | output | NUM_SRC | Edge-trigger configuration |
| model_cfg_o | output | NUM_SRC | Stored model bits |

## Verification
The assertions follow each source cell on every cycle. They check that an acknowledge or clear-pending always leaves the stored flag low, that an edge rise without a clear leaves it high, that a disabled legacy level source never latches from its line, that a legacy end of interrupt re-pends, and that a set-enable takes hold. The bench scenarios show behaviour that spans many cycles or differs between the flavours: the three-edge synchroniser latency, a stored flag surviving a falling line, the generic live report vanishing with the line, the bitmap and configuration field positions, and ignored selector codes.

// File: rtl/itp_pkg.sv
package itp_pkg;

    typedef enum logic {
        REV_LEGACY  = 1'b0,
        REV_GENERIC = 1'b1
    } itp_rev_e;

    typedef enum logic [2:0] {
        SEL_EN_SET   = 3'd0,
        SEL_EN_CLR   = 3'd1,
        SEL_PEND_SET = 3'd2,
        SEL_PEND_CLR = 3'd3,
        SEL_CFG      = 3'd4
    } itp_sel_e;

    typedef struct packed {
        logic pend;
        logic en;
        logic edge_trig;
        logic model;
    } itp_src_t;

endpackage

// File: rtl/itp_line_sync.sv
module itp_line_sync #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] line_i,
    output logic [NUM_SRC-1:0] level_o,
    output logic [NUM_SRC-1:0] rise_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] s1;
        logic [NUM_SRC-1:0] s2;
        logic [NUM_SRC-1:0] lvl;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.s1  = line_i;
        sync_d.s2  = sync_q.s1;
        sync_d.lvl = sync_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign level_o = sync_q.lvl;
    assign rise_o  = sync_q.s2 & ~sync_q.lvl;

    // R1: a quiet synchronised line leaves the recorded level unchanged
    p_quiet_line_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_q.s2 == sync_q.lvl) |=> $stable(sync_q.lvl));

    // R1: a source never sees two rises on consecutive cycles
    p_single_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/itp_wr_decode.sv
module itp_wr_decode #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = $clog2(NUM_SRC / 4)
) (
    input  logic               wr_en_i,
    input  logic [2:0]         wr_sel_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [7:0]         wr_data_i,
    output logic [NUM_SRC-1:0] set_en_o,
    output logic [NUM_SRC-1:0] clr_en_o,
    output logic [NUM_SRC-1:0] set_pend_o,
    output logic [NUM_SRC-1:0] clr_pend_o,
    output logic [NUM_SRC-1:0] cfg_we_o,
    output logic [NUM_SRC-1:0] cfg_edge_o,
    output logic [NUM_SRC-1:0] cfg_model_o
);
    import itp_pkg::*;

    logic [NUM_SRC-1:0] bit_hit;
    logic [NUM_SRC-1:0] cfg_hit;
    itp_sel_e           sel;

    assign sel = itp_sel_e'(wr_sel_i);

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            bit_hit[i]     = (wr_idx_i == IDX_W'(i / 8)) && wr_data_i[i % 8];
            cfg_hit[i]     = (wr_idx_i == IDX_W'(i / 4));
            cfg_edge_o[i]  = wr_data_i[2 * (i % 4) + 1];
            cfg_model_o[i] = wr_data_i[2 * (i % 4)];
        end
    end

    assign set_en_o   = (wr_en_i && sel == SEL_EN_SET)   ? bit_hit : '0;
    assign clr_en_o   = (wr_en_i && sel == SEL_EN_CLR)   ? bit_hit : '0;
    assign set_pend_o = (wr_en_i && sel == SEL_PEND_SET) ? bit_hit : '0;
    assign clr_pend_o = (wr_en_i && sel == SEL_PEND_CLR) ? bit_hit : '0;
    assign cfg_we_o   = (wr_en_i && sel == SEL_CFG)      ? cfg_hit : '0;

endmodule

// File: rtl/itp_src_cell.sv
module itp_src_cell
    import itp_pkg::*;
#(
    parameter itp_rev_e REV = REV_LEGACY
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,
    input  logic lvl_i,
    input  logic set_en_i,
    input  logic clr_en_i,
    input  logic set_pend_i,
    input  logic clr_pend_i,
    input  logic cfg_we_i,
    input  logic cfg_edge_i,
    input  logic cfg_model_i,
    input  logic ack_i,
    input  logic eoi_i,
    output logic pend_o,
    output logic en_o,
    output logic edge_o,
    output logic model_o
);

    localparam logic IS_LEGACY = (REV == REV_LEGACY);

    itp_src_t st_d, st_q;
    logic     pend_set;
    logic     pend_clr;

    always_comb begin
        st_d = st_q;
        if (cfg_we_i) begin
            st_d.edge_trig = cfg_edge_i;
            st_d.model     = cfg_model_i;
        end
        if (set_en_i)      st_d.en = 1'b1;
        else if (clr_en_i) st_d.en = 1'b0;

        pend_set = set_pend_i
                 | (rise_i & (st_q.edge_trig | (IS_LEGACY & st_q.en)))
                 | (set_en_i & ~st_q.edge_trig & lvl_i)
                 | (IS_LEGACY & eoi_i & ~st_q.edge_trig & st_q.en & lvl_i);
        pend_clr = ack_i | clr_pend_i;

        if (pend_clr)      st_d.pend = 1'b0;
        else if (pend_set) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o  = st_q.pend | (~IS_LEGACY & ~st_q.edge_trig & lvl_i);
    assign en_o    = st_q.en;
    assign edge_o  = st_q.edge_trig;
    assign model_o = st_q.model;

    p_ack_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_i |=> !st_q.pend);

    p_clear_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_pend_i |=> !st_q.pend);

    p_edge_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_i && st_q.edge_trig && !ack_i && !clr_pend_i) |=> st_q.pend);

    p_legacy_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (IS_LEGACY && rise_i && !st_q.edge_trig && !st_q.en && !st_q.pend
         && !set_pend_i && !set_en_i) |=> !st_q.pend);

    p_eoi_repend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (IS_LEGACY && eoi_i && st_q.en && !st_q.edge_trig && lvl_i
         && !ack_i && !clr_pend_i) |=> st_q.pend);

    p_set_enable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_en_i |=> st_q.en);

endmodule

// File: rtl/itp_pending_tracker.sv
module itp_pending_tracker
    import itp_pkg::*;
#(
    parameter int       NUM_SRC = 32,
    parameter itp_rev_e REV     = REV_LEGACY,
    localparam int      ID_W    = $clog2(NUM_SRC),
    localparam int      IDX_W   = $clog2(NUM_SRC / 4)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] line_i,
    input  logic               wr_en_i,
    input  logic [2:0]         wr_sel_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [7:0]         wr_data_i,
    input  logic               ack_valid_i,
    input  logic [ID_W-1:0]    ack_id_i,
    input  logic               eoi_valid_i,
    input  logic [ID_W-1:0]    eoi_id_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] enable_o,
    output logic [NUM_SRC-1:0] edge_cfg_o,
    output logic [NUM_SRC-1:0] model_cfg_o
);

    logic [NUM_SRC-1:0] level;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] set_en;
    logic [NUM_SRC-1:0] clr_en;
    logic [NUM_SRC-1:0] set_pend;
    logic [NUM_SRC-1:0] clr_pend;
    logic [NUM_SRC-1:0] cfg_we;
    logic [NUM_SRC-1:0] cfg_edge;
    logic [NUM_SRC-1:0] cfg_model;

    itp_line_sync #(.NUM_SRC(NUM_SRC)) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .line_i  (line_i),
        .level_o (level),
        .rise_o  (rise)
    );

    itp_wr_decode #(.NUM_SRC(NUM_SRC)) dec_i (
        .wr_en_i     (wr_en_i),
        .wr_sel_i    (wr_sel_i),
        .wr_idx_i    (wr_idx_i),
        .wr_data_i   (wr_data_i),
        .set_en_o    (set_en),
        .clr_en_o    (clr_en),
        .set_pend_o  (set_pend),
        .clr_pend_o  (clr_pend),
        .cfg_we_o    (cfg_we),
        .cfg_edge_o  (cfg_edge),
        .cfg_model_o (cfg_model)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        itp_src_cell #(.REV(REV)) cell_i (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .rise_i      (rise[g]),
            .lvl_i       (level[g]),
            .set_en_i    (set_en[g]),
            .clr_en_i    (clr_en[g]),
            .set_pend_i  (set_pend[g]),
            .clr_pend_i  (clr_pend[g]),
            .cfg_we_i    (cfg_we[g]),
            .cfg_edge_i  (cfg_edge[g]),
            .cfg_model_i (cfg_model[g]),
            .ack_i       (ack_valid_i && (ack_id_i == ID_W'(g))),
            .eoi_i       (eoi_valid_i && (eoi_id_i == ID_W'(g))),
            .pend_o      (pend_o[g]),
            .en_o        (enable_o[g]),
            .edge_o      (edge_cfg_o[g]),
            .model_o     (model_cfg_o[g])
        );
    end

    // R10: one write touches at most one target kind
    p_one_target_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |-> ($countones({|set_en, |clr_en, |set_pend, |clr_pend, |cfg_we}) <= 1));

    // R11: state is cleared on the first cycle out of reset
    p_reset_clear_r11: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (enable_o == '0 && edge_cfg_o == '0));

endmodule

// File: tb/itp_pending_tracker_tb_top.sv
module itp_pending_tracker_tb_top;
    import itp_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] line = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [2:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic        ack_v = 1'b0;
    logic [4:0]  ack_id = '0;
    logic        eoi_v = 1'b0;
    logic [4:0]  eoi_id = '0;

    logic [31:0] l_pend, l_en, l_edge, l_model;
    logic [31:0] g_pend, g_en, g_edge, g_model;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    itp_pending_tracker #(.NUM_SRC(32), .REV(REV_LEGACY)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .line_i(line),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .ack_valid_i(ack_v), .ack_id_i(ack_id), .eoi_valid_i(eoi_v), .eoi_id_i(eoi_id),
        .pend_o(l_pend), .enable_o(l_en), .edge_cfg_o(l_edge), .model_cfg_o(l_model)
    );

    itp_pending_tracker #(.NUM_SRC(32), .REV(REV_GENERIC)) dut_gen_i (
        .clk_i(clk), .rst_ni(rst_n), .line_i(line),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .ack_valid_i(ack_v), .ack_id_i(ack_id), .eoi_valid_i(eoi_v), .eoi_id_i(eoi_id),
        .pend_o(g_pend), .enable_o(g_en), .edge_cfg_o(g_edge), .model_cfg_o(g_model)
    );

    // {sel[2:0], idx[2:0], data[7:0], expected[31:0]}; sel 4 checks edge flags, else enables
    localparam logic [45:0] VEC [9] = '{
        {3'd0, 3'd0, 8'h05, 32'h0000_0005},
        {3'd0, 3'd2, 8'h80, 32'h0080_0005},
        {3'd1, 3'd0, 8'h04, 32'h0080_0001},
        {3'd1, 3'd2, 8'h00, 32'h0080_0001},
        {3'd0, 3'd3, 8'hF0, 32'hF080_0001},
        {3'd1, 3'd3, 8'h30, 32'hC080_0001},
        {3'd4, 3'd1, 8'h89, 32'h0000_00A0},
        {3'd4, 3'd7, 8'h02, 32'h1000_00A0},
        {3'd5, 3'd0, 8'hFF, 32'hC080_0001}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic wr(input logic [2:0] s, input logic [2:0] i, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_idx = i; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack(input logic [4:0] id);
        ack_v = 1'b1; ack_id = id;
        @(negedge clk);
        ack_v = 1'b0;
    endtask

    task automatic eoi(input logic [4:0] id);
        eoi_v = 1'b1; eoi_id = id;
        @(negedge clk);
        eoi_v = 1'b0;
    endtask

    task automatic set_line(input int n, input logic v);
        line[n] = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 legacy pend",   l_pend, 32'h0);
        chk("R11 generic pend",  g_pend, 32'h0);
        chk("R11 enables",       l_en | g_en, 32'h0);
        chk("R11 config",        l_edge | l_model | g_edge | g_model, 32'h0);

        // R7 R8 R10: table of register writes
        for (int k = 0; k < 9; k++) begin
            wr(VEC[k][45:43], VEC[k][42:40], VEC[k][39:32]);
            chk("R7/R8/R10 table legacy",
                (VEC[k][45:43] == 3'd4) ? l_edge : l_en, VEC[k][31:0]);
            chk("R7/R8/R10 table generic",
                (VEC[k][45:43] == 3'd4) ? g_edge : g_en, VEC[k][31:0]);
        end
        chk("R10 model bit", l_model, 32'h0000_0010);

        // R1 R2: edge source 5, disabled, line rises
        line[5] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 latency not yet", {31'b0, l_pend[5]}, 32'h0);
        @(negedge clk);
        chk("R2 legacy edge pend", {31'b0, l_pend[5]}, 32'h1);
        chk("R2 generic edge pend", {31'b0, g_pend[5]}, 32'h1);
        ack(5'd5);
        chk("R5 ack edge", {31'b0, l_pend[5] | g_pend[5]}, 32'h0);
        repeat (4) @(negedge clk);
        chk("R1 steady line no repend", {31'b0, l_pend[5] | g_pend[5]}, 32'h0);
        set_line(5, 1'b0);

        // R3 R4: level sources 0 (enabled) and 1 (disabled)
        line[0] = 1'b1; line[1] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3 legacy level", l_pend & 32'h3, 32'h1);
        chk("R4 generic live", g_pend & 32'h3, 32'h3);
        line[0] = 1'b0; line[1] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 legacy stored after fall", l_pend & 32'h3, 32'h1);
        chk("R4 generic follows line", g_pend & 32'h3, 32'h0);
        ack(5'd0);
        chk("R5 legacy ack level", l_pend & 32'h3, 32'h0);

        // R5 R6: ack then end of interrupt with line high
        set_line(0, 1'b1);
        chk("R3 legacy enabled rise", {31'b0, l_pend[0]}, 32'h1);
        ack(5'd0);
        chk("R5 legacy ack", {31'b0, l_pend[0]}, 32'h0);
        chk("R5 generic live after ack", {31'b0, g_pend[0]}, 32'h1);
        eoi(5'd0);
        chk("R6 legacy eoi repend", {31'b0, l_pend[0]}, 32'h1);
        set_line(0, 1'b0);
        chk("R6 legacy stored", {31'b0, l_pend[0]}, 32'h1);
        chk("R6 generic eoi no effect", {31'b0, g_pend[0]}, 32'h0);
        ack(5'd0);

        // R6 R7: disabled level source, eoi ignored, set-enable pends
        set_line(1, 1'b1);
        eoi(5'd1);
        chk("R6 eoi disabled", {31'b0, l_pend[1]}, 32'h0);
        wr(3'd0, 3'd0, 8'h02);
        chk("R7 enable pends legacy", {31'b0, l_pend[1]}, 32'h1);
        set_line(1, 1'b0);
        chk("R7 enable stored legacy", {31'b0, l_pend[1]}, 32'h1);
        chk("R7 enable stored generic", {31'b0, g_pend[1]}, 32'h1);
        wr(3'd3, 3'd0, 8'h02);
        chk("R9 clear pend", {31'b0, l_pend[1] | g_pend[1]}, 32'h0);

        // R9: set/clear pending mapping
        wr(3'd2, 3'd1, 8'h01);
        chk("R9 set pend src8", l_pend & g_pend, 32'h0000_0100);
        wr(3'd3, 3'd1, 8'h00);
        chk("R9 zero clear ignored", l_pend, 32'h0000_0100);
        wr(3'd3, 3'd1, 8'h01);
        chk("R9 clear src8", l_pend | g_pend, 32'h0);
        wr(3'd2, 3'd4, 8'hFF);
        chk("R10 idx beyond bitmap ignored", l_pend | g_pend, 32'h0);

        // R9: set-pending and acknowledge in the same cycle
        ack_v = 1'b1; ack_id = 5'd8;
        wr(3'd2, 3'd1, 8'h01);
        ack_v = 1'b0;
        chk("R9 ack beats set", {31'b0, l_pend[8] | g_pend[8]}, 32'h0);

        // R9: line rise on edge source 7 and clear-pending on the same edge
        line[7] = 1'b1;
        repeat (2) @(negedge clk);
        wr(3'd3, 3'd0, 8'h80);
        chk("R9 clear beats rise", {31'b0, l_pend[7] | g_pend[7]}, 32'h0);
        @(negedge clk);
        chk("R9 clear beats rise hold", {31'b0, l_pend[7] | g_pend[7]}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule